// File: doc/BRIEF.md
# Configuration File Header Section Finder

This block sits in front of a configuration loader and reads the start of a configuration file as a byte stream. The stream must open with a fixed 13-byte preamble. After the preamble comes a chain of tagged sections. Each section has a one-byte letter tag, a big-endian length and then a body of that many bytes. The block walks this chain until it finds the section whose tag the caller asked for. It then reports that section's length and stops taking bytes, so the section's payload is left on the stream for the logic downstream.

The caller pulses `start` with the wanted tag on `want_tag`. Bytes arrive over a valid/ready handshake. The block skips any section that does not match by consuming its body. The search ends in one of three ways: a match, a malformed header, or a byte budget after the preamble running out. The outcome flags stay set until the next `start`.

Top module: `hdr_section_finder`

## Requirements
- R1: After reset, `in_ready`, `found`, `error` and `done` are low and `sect_len` is zero.
- R2: A `start` pulse clears `found`, `error` and `done` on the next cycle and latches `want_tag`. It aborts any search in progress and begins a new one with the preamble. `in_ready` is low during the cycle in which `start` is high.
- R3: The first 13 accepted bytes must be 0x00 0x09 0x0F 0xF0 0x0F 0xF0 0x0F 0xF0 0x0F 0xF0 0x00 0x00 0x01, in that order. The first byte that differs raises `error` and `done` on the next cycle, and nothing further is accepted.
- R4: A tag byte below 0x61 ('a') or above 0x65 ('e') raises `error` and ends the search.
- R5: The tag 0x65 is followed by a 4-byte length. Every other legal tag is followed by a 2-byte length. Lengths are sent most significant byte first.
- R6: A section whose tag is not 0x65 and whose length is above 255 raises `error`, even if its tag is the wanted one. A length of exactly 255 is accepted.
- R7: When the tag of a well-formed section equals the wanted tag, `found` and `done` rise on the cycle after its last length byte. `sect_len` then shows that length, and no further byte is accepted.
- R8: A section that does not match has its body consumed byte for byte and is then followed by the next tag. A zero-length section is followed directly by the next tag.
- R9: Once 100 bytes after the preamble have been accepted, the search ends with `done` high and both `found` and `error` low. The length bytes of a section whose tag is read before the budget runs out are still read.
- R10: `found` and `error` hold their values until the next `start`. `sect_len` is zero whenever `found` is low.
- R11: `in_ready` is high only while a search is under way. A cycle with `in_valid` low consumes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a new search |
| want_tag | input | 8 | Tag to look for, sampled with `start` |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts the byte this cycle |
| found | output | 1 | Wanted section located (sticky) |
| error | output | 1 | Preamble, tag or length fault (sticky) |
| done | output | 1 | Search over, by any outcome |
| sect_len | output | 32 | Length of the found section, zero otherwise |

## Verification
The embedded assertions check the following on every cycle:
- `found` and `error` are never high together, and each holds until `start`.
- `found` only rises right after an accepted byte.
- A found section without the wide tag never reports a length above 255.
- A finished search accepts nothing.
- A start pulse clears the outcome on the next cycle.

The preamble comparison, big-endian length assembly, body skipping and the exact byte on which the budget runs out can only be shown by the bench's scenarios. In those scenarios, a behavioural model predicts how many bytes are taken and which outcome follows, under both steady and stalled input.

// File: rtl/hsf_pkg.sv
// Shared types and constants for the header section finder.
// Assumes byte-wide streams and lowercase ASCII tags.
package hsf_pkg;

    localparam int PRE_LEN = 13;
    localparam logic [7:0] TAG_LO   = 8'h61;
    localparam logic [7:0] TAG_HI   = 8'h65;
    localparam logic [7:0] TAG_WIDE = 8'h65;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_TAG,
        S_LEN,
        S_SKIP,
        S_DONE
    } hsf_state_e;

    // Expected preamble byte at a given position.
    function automatic logic [7:0] hsf_preamble_byte(input int unsigned idx);
        if (idx == 0)                   return 8'h00;
        if (idx == 1)                   return 8'h09;
        if (idx == 10 || idx == 11)     return 8'h00;
        if (idx == 12)                  return 8'h01;
        if (idx > 12)                   return 8'h00;
        return (idx % 2 == 0) ? 8'h0F : 8'hF0;
    endfunction

endpackage

// File: rtl/hsf_preamble_check.sv
// Tracks the position inside the fixed preamble and compares the incoming
// byte with the expected one. Assumes the parent stops feeding it after a
// mismatch or after the last position.
module hsf_preamble_check
    import hsf_pkg::*;
#(
    parameter int PLEN = PRE_LEN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       take,
    input  logic [7:0] byte_in,
    output logic       match,
    output logic       last
);
    localparam int IW = $clog2(PLEN);

    logic [IW-1:0] idx_q;

    // Position counter: restarts on clear, advances on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                idx_q <= '0;
        else if (clear)            idx_q <= '0;
        else if (take && !last)    idx_q <= idx_q + 1'b1;
    end

    assign match = (byte_in == hsf_preamble_byte(32'(idx_q)));
    assign last  = (idx_q == IW'(PLEN - 1));

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IW'(PLEN - 1));

endmodule

// File: rtl/hsf_len_accum.sv
// Shifts length bytes in, most significant first. Assumes clear is given
// before each new length field so that short fields start from zero.
module hsf_len_accum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         take,
    input  logic [7:0]   byte_in,
    output logic [W-1:0] value
);
    // Accumulator: zeroed on clear, shifted by one byte on take.
    always_ff @(posedge clk) begin
        if (!rst_n)      value <= '0;
        else if (clear)  value <= '0;
        else if (take)   value <= {value[W-9:0], byte_in};
    end

endmodule

// File: rtl/hsf_budget.sv
// Counts header bytes accepted after the preamble and saturates at LIMIT.
// at_last marks that the next accepted byte uses up the budget.
module hsf_budget #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic take,
    output logic spent,
    output logic at_last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Saturating byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 cnt_q <= '0;
        else if (clear)                             cnt_q <= '0;
        else if (take && cnt_q < CW'(LIMIT))        cnt_q <= cnt_q + 1'b1;
    end

    assign spent   = (cnt_q == CW'(LIMIT));
    assign at_last = (cnt_q == CW'(LIMIT - 1));

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/hdr_section_finder.sv
// Streaming header section finder. Checks the preamble, then walks tagged
// sections until the wanted tag is met, a fault is seen or the byte budget
// after the preamble runs out. Assumes want_tag is valid with start.
module hdr_section_finder
    import hsf_pkg::*;
#(
    parameter int LEN_W        = 32,
    parameter int SEARCH_LIMIT = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       want_tag,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             found,
    output logic             error,
    output logic             done,
    output logic [LEN_W-1:0] sect_len
);
    localparam logic [LEN_W-1:0] SHORT_MAX = LEN_W'(255);

    hsf_state_e       state_q;
    logic [7:0]       want_q;
    logic             wide_q;
    logic             hit_q;
    logic [2:0]       len_left_q;
    logic [LEN_W-1:0] skip_q;
    logic             found_q;
    logic             err_q;

    logic             take;
    logic             active;
    logic             pre_match;
    logic             pre_last;
    logic             spent;
    logic             at_last;
    logic             reached;
    logic             tag_ok;
    logic [LEN_W-1:0] len_value;
    logic [LEN_W-1:0] full_len;

    assign active   = state_q inside {S_PRE, S_TAG, S_LEN, S_SKIP};
    assign in_ready = active && !start;
    assign take     = in_valid && in_ready;
    assign reached  = spent || at_last;
    assign tag_ok   = (in_data >= TAG_LO) && (in_data <= TAG_HI);
    assign full_len = {len_value[LEN_W-9:0], in_data};

    hsf_preamble_check #(.PLEN(PRE_LEN)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .take    (take && state_q == S_PRE),
        .byte_in (in_data),
        .match   (pre_match),
        .last    (pre_last)
    );

    hsf_len_accum #(.W(LEN_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start || (take && state_q == S_TAG)),
        .take    (take && state_q == S_LEN),
        .byte_in (in_data),
        .value   (len_value)
    );

    hsf_budget #(.LIMIT(SEARCH_LIMIT)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .take    (take && state_q inside {S_TAG, S_LEN, S_SKIP}),
        .spent   (spent),
        .at_last (at_last)
    );

    // Search sequencer: start re-arms, each accepted byte moves the walk on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            want_q     <= '0;
            wide_q     <= 1'b0;
            hit_q      <= 1'b0;
            len_left_q <= '0;
            skip_q     <= '0;
            found_q    <= 1'b0;
            err_q      <= 1'b0;
        end else if (start) begin
            state_q <= S_PRE;
            want_q  <= want_tag;
            found_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (take) begin
            case (state_q)
                S_PRE: begin
                    if (!pre_match) begin
                        err_q   <= 1'b1;
                        state_q <= S_DONE;
                    end else if (pre_last) begin
                        state_q <= S_TAG;
                    end
                end
                S_TAG: begin
                    if (!tag_ok) begin
                        err_q   <= 1'b1;
                        state_q <= S_DONE;
                    end else begin
                        wide_q     <= (in_data == TAG_WIDE);
                        hit_q      <= (in_data == want_q);
                        len_left_q <= (in_data == TAG_WIDE) ? 3'd4 : 3'd2;
                        state_q    <= S_LEN;
                    end
                end
                S_LEN: begin
                    len_left_q <= len_left_q - 3'd1;
                    if (len_left_q == 3'd1) begin
                        if (!wide_q && full_len > SHORT_MAX) begin
                            err_q   <= 1'b1;
                            state_q <= S_DONE;
                        end else if (hit_q) begin
                            found_q <= 1'b1;
                            state_q <= S_DONE;
                        end else if (full_len == '0 || reached) begin
                            state_q <= reached ? S_DONE : S_TAG;
                        end else begin
                            skip_q  <= full_len;
                            state_q <= S_SKIP;
                        end
                    end
                end
                S_SKIP: begin
                    skip_q <= skip_q - 1'b1;
                    if (reached)                  state_q <= S_DONE;
                    else if (skip_q == LEN_W'(1)) state_q <= S_TAG;
                end
                default: state_q <= state_q;
            endcase
        end
    end

    assign found    = found_q;
    assign error    = err_q;
    assign done     = (state_q == S_DONE);
    assign sect_len = found_q ? len_value : '0;

    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && error));

    assert_found_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        found && !start |=> found);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        error && !start |=> error);

    assert_found_on_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found) |-> $past(in_valid && in_ready));

    assert_short_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        found && want_q != TAG_WIDE |-> sect_len <= SHORT_MAX);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !in_ready);

    assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !found && !error && !done);

endmodule

// File: tb/hdr_section_finder_bench.sv
module hdr_section_finder_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  want_tag;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_ready;
    logic        found;
    logic        error;
    logic        done;
    logic [31:0] sect_len;

    always #5 clk = ~clk;

    hdr_section_finder u_hdr_section_finder (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .want_tag (want_tag),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .found    (found),
        .error    (error),
        .done     (done),
        .sect_len (sect_len)
    );

    int checks = 0;
    int errors = 0;

    byte unsigned s[$];
    logic [7:0]   cur_want;

    // behavioural model state
    bit          m_run = 0;
    bit          m_fin = 0;
    int          m_cons = 0;
    int          m_end = 0;
    int          m_out = 0;     // 0 miss, 1 found, 2 error
    logic [31:0] m_len = 0;

    function automatic int sb(int i);
        return (i < s.size()) ? int'(s[i]) : 0;
    endfunction

    // Predicts bytes taken and outcome of a search over the current stream.
    function automatic void analyze(input logic [7:0] want, output int endc,
                                    output int outc, output logic [31:0] len);
        int pre[13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                        8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
        int p;
        int n;
        int tag;
        int nb;
        longint L;
        len = 0;
        for (int i = 0; i < 13; i++) begin
            if (sb(i) != pre[i]) begin
                endc = i + 1; outc = 2; return;
            end
        end
        p = 13; n = 0;
        while (n < 100) begin
            tag = sb(p); p++; n++;
            if (tag < 97 || tag > 101) begin endc = p; outc = 2; return; end
            nb = (tag == 101) ? 4 : 2;
            L = 0;
            for (int k = 0; k < nb; k++) begin L = L * 256 + sb(p); p++; n++; end
            if (tag != 101 && L > 255) begin endc = p; outc = 2; return; end
            if (tag == int'(want)) begin endc = p; outc = 1; len = L[31:0]; return; end
            for (longint i = 0; i < L && n < 100; i++) begin p++; n++; end
        end
        endc = p; outc = 0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic compare(input bit st);
        bit exp_found;
        exp_found = m_fin && m_out == 1;
        chk("R11 in_ready", {31'd0, in_ready}, {31'd0, m_run && !st && m_cons < m_end});
        chk("R7 found", {31'd0, found}, {31'd0, exp_found});
        chk("R3 R4 R6 error", {31'd0, error}, {31'd0, m_fin && m_out == 2});
        chk("R9 done", {31'd0, done}, {31'd0, m_fin});
        chk("R5 R10 sect_len", sect_len, exp_found ? m_len : 32'd0);
    endtask

    // One clock: drive inputs, compare with the model, advance the model.
    task automatic drive_cycle(input bit st, input bit vld);
        @(negedge clk);
        start    = st;
        want_tag = cur_want;
        in_valid = vld;
        in_data  = vld ? 8'(sb(m_cons)) : 8'h00;
        #1;
        compare(st);
        if (st) begin
            m_run = 1; m_fin = 0; m_cons = 0;
            analyze(cur_want, m_end, m_out, m_len);
        end else if (vld && m_run && m_cons < m_end) begin
            m_cons++;
            if (m_cons == m_end) begin m_run = 0; m_fin = 1; end
        end
    endtask

    task automatic run_search(input logic [7:0] want, input bit stall);
        cur_want = want;
        drive_cycle(1, 0);
        for (int c = 0; c < 3000 && !m_fin; c++)
            drive_cycle(0, stall ? ($urandom_range(0, 2) != 0) : 1'b1);
        for (int c = 0; c < 4; c++) drive_cycle(0, 1);  // R11: finished, nothing taken
    endtask

    task automatic push_pre();
        byte unsigned p[13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                                8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
        s = {};
        for (int i = 0; i < 13; i++) s.push_back(p[i]);
    endtask

    task automatic push_sect(input byte unsigned tag, input logic [31:0] len, input bit body);
        s.push_back(tag);
        if (tag == 8'h65) begin
            s.push_back(len[31:24]); s.push_back(len[23:16]);
        end
        s.push_back(len[15:8]); s.push_back(len[7:0]);
        if (body) for (int i = 0; i < int'(len); i++) s.push_back(8'hAA);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; start = 0; want_tag = 0; in_valid = 0; in_data = 0; cur_want = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 in_ready", {31'd0, in_ready}, 32'd0);
        chk("R1 found", {31'd0, found}, 32'd0);
        chk("R1 error", {31'd0, error}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 sect_len", sect_len, 32'd0);

        // R5 R7 R8: skip a and b, find wide-length e
        push_pre(); push_sect("a", 3, 1); push_sect("b", 2, 1); push_sect("e", 32'h0001_2345, 0);
        run_search("e", 0);
        chk("R5 wide length", sect_len, 32'h0001_2345);
        chk("R7 found", {31'd0, found}, 32'd1);

        // R6 boundary 255 accepted, with stalls (R11)
        push_pre(); push_sect("a", 5, 1); push_sect("c", 255, 0);
        run_search("c", 1);
        chk("R6 length 255 accepted", sect_len, 32'd255);

        // R6 length 256 on wanted tag is an error
        push_pre(); push_sect("a", 256, 0);
        run_search("a", 0);
        chk("R6 length over 255", {31'd0, error}, 32'd1);
        chk("R6 not found", {31'd0, found}, 32'd0);

        // R3 preamble mismatch at byte 7
        push_pre(); s[7] = 8'h77; push_sect("a", 1, 1);
        run_search("a", 1);
        chk("R3 preamble mismatch", {31'd0, error}, 32'd1);
        chk("R3 bytes taken", m_cons, 32'd8);

        // R4 bad tags above and below the range
        push_pre(); push_sect("a", 1, 1); s.push_back(8'h66); s.push_back(0); s.push_back(1);
        run_search("b", 0);
        chk("R4 tag 0x66", {31'd0, error}, 32'd1);
        push_pre(); s.push_back(8'h60); s.push_back(0); s.push_back(1);
        run_search("a", 0);
        chk("R4 tag 0x60", {31'd0, error}, 32'd1);

        // R9 budget runs out inside a long body
        push_pre(); push_sect("a", 200, 1);
        run_search("b", 1);
        chk("R9 miss found", {31'd0, found}, 32'd0);
        chk("R9 miss error", {31'd0, error}, 32'd0);
        chk("R9 miss done", {31'd0, done}, 32'd1);
        chk("R9 bytes taken", m_cons, 32'd113);

        // R8 zero-length section and wide section skipped
        push_pre(); push_sect("d", 0, 0); push_sect("e", 16, 1); push_sect("b", 7, 0);
        run_search("b", 0);
        chk("R8 found after skips", sect_len, 32'd7);

        // R2 restart mid-search; R10 flags cleared by start
        push_pre(); push_sect("a", 200, 1);
        cur_want = "b";
        drive_cycle(1, 0);
        for (int c = 0; c < 20; c++) drive_cycle(0, 1);
        push_pre(); push_sect("b", 9, 0);
        run_search("b", 0);
        chk("R2 restart finds", sect_len, 32'd9);
        cur_want = "a";
        drive_cycle(1, 0);
        drive_cycle(0, 0);
        chk("R2 R10 cleared by start", {29'd0, found, error, done}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule